// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Event Flags

This block is a 12-bit up-counter that advances on one of three externally supplied clock-enable ticks and, after reaching its all-ones value, restarts from a software-programmed reload value instead of zero. A small byte-wide register bus configures it. Software picks the tick source, sets the reload and compare values, reads the counter, and reads and clears two event flags: one for overflow and one for compare match.

Each flag has its own enable and drives its own interrupt request. A wake-request output tells the power controller when a flagged event may end a low-power state. The allowed events depend on the state the power controller reports. In the idle-wait state, either interrupt wakes the chip. In the clock-kept halt state, only an overflow wakes it, and only when the slowest-but-kept tick source is selected. Full halt never wakes.

The overflow flag is cleared by reading the control/status byte. The clear does not take effect at once: the flag stays set until the next selected counter tick.

Top module: `reload_tick_timer`

## Requirements
- R1: After a synchronous reset, every readable register reads 0x00 and `ovf_irq`, `cmp_irq` and `wake_req` are low.
- R2: Address 0 is the control/status byte. Bits [4:3] hold the tick select, bit 2 is the overflow flag, bit 1 is the overflow interrupt enable and bit 0 is the compare interrupt enable. Bits [7:5] always read 0. A write to bit 2 or to bits [7:5] has no effect.
- R3: Tick select 00 holds the counter still. Selects 01, 10 and 11 take `tick_in[0]`, `tick_in[1]` and `tick_in[2]` respectively, and the counter rises by one on each cycle in which the selected tick is high.
- R4: On a selected tick while the counter is 0xFFF, the counter loads the reload value (addresses 1 and 2, low byte and high nibble) and the overflow flag sets.
- R5: A read of address 0 while the overflow flag is set returns bit 2 = 1. The flag then stays set through any number of cycles until the next selected tick strictly after that read, and clears on that tick.
- R6: An overflow in the same cycle as a clearing read, or in the cycle that would drop the flag, leaves the flag set and cancels the pending clear.
- R7: The compare flag (address 7, bit 0) sets on a selected tick that makes the counter equal the compare value (addresses 3 and 4). A read of address 7 clears it, unless a new match happens in that same cycle.
- R8: `ovf_irq` is high exactly while the overflow flag and its enable are both set. `cmp_irq` is high exactly while the compare flag and its enable are both set.
- R9: `wake_req` follows `pwr_mode`. In mode 1 (wait) it is the OR of both interrupts. In mode 2 (clock-kept halt) it equals `ovf_irq` only when tick select is 01. In mode 0 (run) and mode 3 (full halt) it is 0.
- R10: Reload and compare bytes read back as written (the high nibble at addresses 2 and 4, with bits [7:4] reading 0). Addresses 5 and 6 return the counter's low byte and high nibble. Writes to addresses 5, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 3 | Prescaled clock-enable ticks, one per tick-select value 01..11 |
| pwr_mode | input | 2 | Power state: 0 run, 1 wait, 2 clock-kept halt, 3 full halt |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| wake_req | output | 1 | Request to leave the current low-power state |

## Verification
The bench builds the block with its default 12-bit counter and 2-bit tick select. This makes all three tick inputs and the stopped setting reachable. The random phase biases the reload high nibble toward 0xF, so the counter overflows every few dozen ticks. That brings the overflow-versus-clearing-read collisions and the delayed flag drop into reach many times. A directed pass counts the full 4096-tick span from zero once, then sets the reload to 0xFFE so that overflows fall on every second tick.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam int DATA_W    = 8;
    localparam int SEL_W     = 2;
    localparam int ADDR_W    = 3;
    localparam int NUM_TICKS = (1 << SEL_W) - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_RLD_LO = 3'd1,
        A_RLD_HI = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4,
        A_CNT_LO = 3'd5,
        A_CNT_HI = 3'd6,
        A_CMPST  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_WAIT  = 2'd1,
        PM_AHALT = 2'd2,
        PM_HALT  = 2'd3
    } pwr_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic             ovf_ie;
        logic             cmp_ie;
    } ctrl_t;

    localparam logic [SEL_W-1:0] SEL_STOP       = '0;
    localparam logic [SEL_W-1:0] SEL_AHALT_WAKE = SEL_W'(1);

    function automatic logic [DATA_W-1:0] pack_status(input ctrl_t c, input logic ovf);
        return {{(DATA_W-SEL_W-3){1'b0}}, c.clk_sel, ovf, c.ovf_ie, c.cmp_ie};
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.clk_sel = d[SEL_W+2:3];
        c.ovf_ie  = d[1];
        c.cmp_ie  = d[0];
        return c;
    endfunction

endpackage

// File: rtl/rtt_counter.sv
module rtt_counter
    import rtt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     clk_sel,
    input  logic [NUM_TICKS-1:0] tick_in,
    input  logic [CNT_W-1:0]     reload,
    input  logic [CNT_W-1:0]     cmp_val,
    output logic [CNT_W-1:0]     cnt,
    output logic                 step,
    output logic                 ovf_ev,
    output logic                 cmp_ev
);

    logic [NUM_TICKS:0] tick_vec;
    logic [CNT_W-1:0]   cnt_nxt;

    assign tick_vec[0] = 1'b0;
    for (genvar g = 1; g <= NUM_TICKS; g++) begin : g_tick
        assign tick_vec[g] = tick_in[g-1];
    end

    assign step    = tick_vec[clk_sel];
    assign ovf_ev  = step && (cnt == '1);
    assign cnt_nxt = ovf_ev ? reload : cnt + 1'b1;
    assign cmp_ev  = step && (cnt_nxt == cmp_val);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= cnt_nxt;
    end

    // R4
    reload_load_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> cnt == $past(reload));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SEL_STOP) |=> $stable(cnt));

    // R3
    step_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ovf_ev) |=> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/rtt_flags.sv
module rtt_flags
    import rtt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  logic      ovf_ev,
    input  logic      cmp_ev,
    input  logic      rd_ctrl,
    input  logic      rd_cmpst,
    input  ctrl_t     ctrl,
    input  pwr_mode_e mode,
    output logic      ovf_flag,
    output logic      cmp_flag,
    output logic      ovf_irq,
    output logic      cmp_irq,
    output logic      wake_req
);

    logic clr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            clr_pend <= 1'b0;
        end else if (ovf_ev) begin
            ovf_flag <= 1'b1;
            clr_pend <= 1'b0;
        end else if (clr_pend && step) begin
            ovf_flag <= 1'b0;
            clr_pend <= 1'b0;
        end else if (rd_ctrl && ovf_flag) begin
            clr_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cmp_flag <= 1'b0;
        else if (cmp_ev)   cmp_flag <= 1'b1;
        else if (rd_cmpst) cmp_flag <= 1'b0;
    end

    assign ovf_irq = ovf_flag && ctrl.ovf_ie;
    assign cmp_irq = cmp_flag && ctrl.cmp_ie;

    always_comb begin
        unique case (mode)
            PM_WAIT:  wake_req = ovf_irq || cmp_irq;
            PM_AHALT: wake_req = ovf_irq && (ctrl.clk_sel == SEL_AHALT_WAKE);
            default:  wake_req = 1'b0;
        endcase
    end

    // R6
    ovf_win_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> ovf_flag);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && ovf_flag && !step) |=> ovf_flag);

    // R5
    ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && step && !ovf_ev) |=> !ovf_flag);

    // R7
    cmp_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_ev |=> cmp_flag);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_HALT || mode == PM_RUN) |-> !wake_req);

endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
    import rtt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ovf_flag,
    input  logic              cmp_flag,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              rd_ctrl,
    output logic              rd_cmpst,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = 2*DATA_W - CNT_W;

    reg_addr_e         addr;
    logic              wr, rd;
    logic [2*DATA_W-1:0] rld_x, cmp_x, cnt_x;

    assign addr     = reg_addr_e'(bus_addr);
    assign wr       = bus_sel && bus_we;
    assign rd       = bus_sel && !bus_we;
    assign rd_ctrl  = rd && (addr == A_CTRL);
    assign rd_cmpst = rd && (addr == A_CMPST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            reload  <= '0;
            cmp_val <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:   ctrl                   <= unpack_ctrl(bus_wdata);
                A_RLD_LO: reload[DATA_W-1:0]     <= bus_wdata;
                A_RLD_HI: reload[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
                A_CMP_LO: cmp_val[DATA_W-1:0]    <= bus_wdata;
                A_CMP_HI: cmp_val[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
                default:  ;
            endcase
        end
    end

    assign rld_x = {{PAD_W{1'b0}}, reload};
    assign cmp_x = {{PAD_W{1'b0}}, cmp_val};
    assign cnt_x = {{PAD_W{1'b0}}, cnt};

    always_comb begin
        unique case (addr)
            A_CTRL:   bus_rdata = pack_status(ctrl, ovf_flag);
            A_RLD_LO: bus_rdata = rld_x[DATA_W-1:0];
            A_RLD_HI: bus_rdata = rld_x[2*DATA_W-1:DATA_W];
            A_CMP_LO: bus_rdata = cmp_x[DATA_W-1:0];
            A_CMP_HI: bus_rdata = cmp_x[2*DATA_W-1:DATA_W];
            A_CNT_LO: bus_rdata = cnt_x[DATA_W-1:0];
            A_CNT_HI: bus_rdata = cnt_x[2*DATA_W-1:DATA_W];
            A_CMPST:  bus_rdata = {{(DATA_W-1){1'b0}}, cmp_flag};
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |-> bus_rdata[DATA_W-1:SEL_W+3] == '0);

    // R10
    cnt_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr >= A_CNT_LO) |=> ($stable(reload) && $stable(cmp_val) && $stable(ctrl)));

endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
    import rtt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TICKS-1:0] tick_in,
    input  logic [1:0]           pwr_mode,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 ovf_irq,
    output logic                 cmp_irq,
    output logic                 wake_req
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, cmp_val, cnt;
    logic             step, ovf_ev, cmp_ev;
    logic             rd_ctrl, rd_cmpst;
    logic             ovf_flag, cmp_flag;

    rtt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .cnt(cnt),
        .ctrl(ctrl), .reload(reload), .cmp_val(cmp_val),
        .rd_ctrl(rd_ctrl), .rd_cmpst(rd_cmpst), .bus_rdata(bus_rdata)
    );

    rtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .clk_sel(ctrl.clk_sel), .tick_in(tick_in),
        .reload(reload), .cmp_val(cmp_val),
        .cnt(cnt), .step(step), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev)
    );

    rtt_flags u_flags (
        .clk(clk), .rst(rst),
        .step(step), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev),
        .rd_ctrl(rd_ctrl), .rd_cmpst(rd_cmpst),
        .ctrl(ctrl), .mode(pwr_mode_e'(pwr_mode)),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .ovf_irq(ovf_irq), .cmp_irq(cmp_irq), .wake_req(wake_req)
    );

endmodule

// File: tb/test_reload_tick_timer.sv
module test_reload_tick_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tick_in = '0;
    logic [1:0] pwr_mode = '0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ovf_irq, cmp_irq, wake_req;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] last_rd;

    always #2 clk = ~clk;

    reload_tick_timer i_reload_tick_timer (
        .clk(clk), .rst(rst), .tick_in(tick_in), .pwr_mode(pwr_mode),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq), .wake_req(wake_req)
    );

    // reference model state
    logic [1:0]  m_sel;
    logic        m_oie, m_cie, m_ovf, m_pend, m_cmpf;
    logic [11:0] m_cnt, m_rld, m_cmp;

    task automatic model_reset();
        m_sel = 0; m_oie = 0; m_cie = 0; m_ovf = 0; m_pend = 0; m_cmpf = 0;
        m_cnt = 0; m_rld = 0; m_cmp = 0;
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {3'b0, m_sel, m_ovf, m_oie, m_cie};
            3'd1: return m_rld[7:0];
            3'd2: return {4'b0, m_rld[11:8]};
            3'd3: return m_cmp[7:0];
            3'd4: return {4'b0, m_cmp[11:8]};
            3'd5: return m_cnt[7:0];
            3'd6: return {4'b0, m_cnt[11:8]};
            default: return {7'b0, m_cmpf};
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        if (a == 3'd0) return "R5";
        if (a == 3'd7) return "R7";
        return "R10";
    endfunction

    function automatic logic model_wake(input logic [1:0] m);
        logic oi, ci;
        oi = m_ovf && m_oie;
        ci = m_cmpf && m_cie;
        if (m == 2'd1) return oi || ci;
        if (m == 2'd2) return oi && (m_sel == 2'b01);
        return 1'b0;
    endfunction

    task automatic model_step(input logic s, input logic w, input logic [2:0] a,
                              input logic [7:0] d, input logic [2:0] t);
        logic        tk, oev, cev;
        logic [11:0] nxt;
        tk  = (m_sel == 2'd0) ? 1'b0 : t[m_sel - 2'd1];
        oev = tk && (m_cnt == 12'hFFF);
        nxt = tk ? (oev ? m_rld : m_cnt + 12'd1) : m_cnt;
        cev = tk && (nxt == m_cmp);
        if (oev) begin m_ovf = 1; m_pend = 0; end
        else if (m_pend && tk) begin m_ovf = 0; m_pend = 0; end
        else if (s && !w && a == 3'd0 && m_ovf) m_pend = 1;
        if (cev) m_cmpf = 1;
        else if (s && !w && a == 3'd7) m_cmpf = 0;
        m_cnt = nxt;
        if (s && w) begin
            case (a)
                3'd0: begin m_sel = d[4:3]; m_oie = d[1]; m_cie = d[0]; end
                3'd1: m_rld[7:0]  = d;
                3'd2: m_rld[11:8] = d[3:0];
                3'd3: m_cmp[7:0]  = d;
                3'd4: m_cmp[11:8] = d[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // one cycle: drive after negedge, check, clock, advance model
    task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                       input logic [7:0] d, input logic [2:0] t, input logic [1:0] m);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; tick_in = t; pwr_mode = m;
        #1;
        if (s && !w) chk(addr_tag(a), bus_rdata, model_read(a));
        chk("R8 ovf_irq", {7'b0, ovf_irq}, {7'b0, m_ovf && m_oie});
        chk("R8 cmp_irq", {7'b0, cmp_irq}, {7'b0, m_cmpf && m_cie});
        chk("R9 wake", {7'b0, wake_req}, {7'b0, model_wake(m)});
        last_rd = bus_rdata;
        @(posedge clk);
        model_step(s, w, a, d, t);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1, 1, a, d, 3'b000, 2'd0);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(1, 0, a, 8'h00, 3'b000, 2'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a));
            chk("R1 reset read", last_rd, 8'h00);
        end

        // R2 reserved and flag bits not writable
        wr(3'd0, 8'hFF);
        rd(3'd0);
        chk("R2 ctrl readback", last_rd, 8'h1B);

        // R10 reload/compare readback, counter not writable
        wr(3'd1, 8'hFE); wr(3'd2, 8'hAF);
        rd(3'd2); chk("R10 reload hi", last_rd, 8'h0F);
        wr(3'd5, 8'h55); rd(3'd5); chk("R10 cnt lo ignores write", last_rd, 8'h00);

        // R3 select 01: tick_in[1] ignored, tick_in[0] counts
        wr(3'd0, 8'h08);
        cyc(0, 0, 0, 0, 3'b110, 0);
        rd(3'd5); chk("R3 wrong tick ignored", last_rd, 8'h00);
        cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd5); chk("R3 selected tick counts", last_rd, 8'h01);
        // select 00 stops
        wr(3'd0, 8'h00);
        cyc(0, 0, 0, 0, 3'b111, 0);
        rd(3'd5); chk("R3 stopped", last_rd, 8'h01);

        // R4 run up to FFF then overflow into reload FFE
        wr(3'd0, 8'h0A);
        for (int i = 0; i < 4094; i++) cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd6); chk("R4 at FFF hi", last_rd, 8'h0F);
        cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd5); chk("R4 reload lo", last_rd, 8'hFE);
        chk("R4 ovf_irq", {7'b0, ovf_irq}, 8'h01);

        // R5 delayed clear
        rd(3'd0); chk("R5 read shows flag", last_rd[2] ? 8'h01 : 8'h00, 8'h01);
        rd(3'd0); chk("R5 flag held before tick", last_rd[2] ? 8'h01 : 8'h00, 8'h01);
        cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd0); chk("R5 flag dropped on tick", last_rd[2] ? 8'h01 : 8'h00, 8'h00);

        // R6 overflow coincides with clearing read, then with dropping tick
        cyc(0, 0, 0, 0, 3'b001, 0);
        cyc(0, 0, 0, 0, 3'b001, 0);
        cyc(1, 0, 3'd0, 0, 3'b001, 0);
        cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd0); chk("R6 read+overflow keeps flag", last_rd[2] ? 8'h01 : 8'h00, 8'h01);
        cyc(0, 0, 0, 0, 3'b001, 0);
        rd(3'd0); chk("R6 drop tick overflow keeps flag", last_rd[2] ? 8'h01 : 8'h00, 8'h01);

        // R7 compare flag and R9 wake
        wr(3'd3, 8'hFF); wr(3'd4, 8'h0F); wr(3'd0, 8'h0B);
        cyc(0, 0, 0, 0, 3'b001, 0);
        cyc(0, 0, 0, 0, 3'b001, 0);
        chk("R8 cmp_irq set", {7'b0, cmp_irq}, 8'h01);
        rd(3'd7); chk("R7 cmp flag set", last_rd, 8'h01);
        rd(3'd7); chk("R7 cmp flag cleared", last_rd, 8'h00);
        cyc(0, 0, 0, 0, 3'b000, 2'd2);
        chk("R9 ahalt wake sel01", {7'b0, wake_req}, 8'h01);
        wr(3'd0, 8'h12);
        cyc(0, 0, 0, 0, 3'b000, 2'd2);
        chk("R9 ahalt no wake sel10", {7'b0, wake_req}, 8'h00);
        cyc(0, 0, 0, 0, 3'b000, 2'd3);
        chk("R9 full halt no wake", {7'b0, wake_req}, 8'h00);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            int r;
            r = int'($urandom_range(0, 99));
            a = 3'($urandom);
            d = 8'($urandom);
            if (a == 3'd2 || a == 3'd4) d[3:0] = ($urandom_range(0, 3) != 0) ? 4'hF : d[3:0];
            if (r < 8)       cyc(1, 1, a, d, 3'($urandom), 2'($urandom));
            else if (r < 35) cyc(1, 0, a, 8'h00, 3'($urandom), 2'($urandom));
            else             cyc(0, 0, 0, 0, 3'($urandom), 2'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule